// File: doc/BRIEF.md
# Radix-Configurable Logarithmic Shifter

This block is a purely combinational barrel shifter for an N-bit word. It is built as a chain of layers. The shift amount is split into base-R digits, and digit L steers layer L. That layer moves its input by the digit times R to the power L. Radix 2 gives the familiar binary chain of layers that shift by 0 or 2^L. A larger radix needs fewer layers, but each layer needs a wider multiplexer. The radix must be a power of two.

A two-bit mode input picks the operation. Bit 0 selects the right direction and bit 1 selects arithmetic fill. A right shift with arithmetic fill copies the sign bit into the vacated positions. Every other combination fills with zeros, and arithmetic left behaves the same as logical left. The shift-amount port may be wider than the range the layers cover. Any amount of N or more drives the whole word to the fill value.

Top module: `log_shifter`

## Requirements
- R1: With mode 2'b00 (logical left) and an amount below N, the output is the input moved toward the MSB by the amount, with zeros entering at bit 0.
- R2: With mode 2'b01 (logical right) and an amount below N, the output is the input moved toward bit 0 by the amount, with zeros entering at the MSB.
- R3: With mode 2'b11 (arithmetic right) and an amount below N, the output is the input moved toward bit 0 by the amount, with copies of input bit N-1 entering at the MSB.
- R4: Mode 2'b10 produces exactly the logical-left result.
- R5: An amount of zero returns the input unchanged in every mode.
- R6: In modes 2'b00, 2'b01 and 2'b10, any amount of N or more gives an all-zero output.
- R7: In mode 2'b11, any amount of N or more gives N copies of input bit N-1.
- R8: The output does not depend on the RADIX parameter: a radix-2 build and a radix-4 build give identical results for every input.
- R9: Every amount from 0 to N-1 is correct, so every digit value in every layer is covered, including the top layer, whose larger digits would overshoot N on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N | Word to be shifted |
| amt_i | input | AMT_W | Unsigned shift distance |
| mode_i | input | 2 | Bit 0: direction (1 = right); bit 1: arithmetic fill |
| data_o | output | N | Shifted word |

## Verification
The bench builds two copies with N=32 and AMT_W=8. One copy uses RADIX=2, which gives five single-bit layers. The other uses RADIX=4, which gives three layers of four-way selection. In the radix-4 build, the top layer's digits 2 and 3 would shift past the word on their own. Both copies are compared against the language's own shift operators for every amount from 0 to 39 in all four modes, with random and sign-extreme data. This reaches every digit of every layer and the boundary at N. A fixed vector table adds the largest encodable amount.

// File: rtl/log_shifter_pkg.sv
package log_shifter_pkg;

  // number of bits needed to index v choices (v >= 1)
  function automatic int bits_for(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  // smallest layer count c with r**c >= n (at least one layer)
  function automatic int layers_for(input int n, input int r);
    int c;
    longint p;
    c = 0;
    p = 1;
    while (p < n) begin
      p = p * r;
      c++;
    end
    if (c == 0) c = 1;
    return c;
  endfunction

  // unit step of layer l: r**l
  function automatic longint step_of(input int r, input int l);
    longint p;
    p = 1;
    for (int i = 0; i < l; i++) p = p * r;
    return p;
  endfunction

endpackage

// File: rtl/lsh_layer.sv
module lsh_layer #(
  parameter int N     = 32,
  parameter int R     = 4,
  parameter longint STEP = 1,
  parameter int DB    = 2
) (
  input  logic [N-1:0]  d_in,
  input  logic [DB-1:0] digit,
  input  logic          fill,
  output logic [N-1:0]  d_out
);
  logic [N-1:0] opt [R];

  for (genvar k = 0; k < R; k++) begin : g_opt
    localparam longint SH = k * STEP;
    if (SH == 0) begin : g_pass
      assign opt[k] = d_in;
    end else if (SH >= N) begin : g_flush
      assign opt[k] = {N{fill}};
    end else begin : g_move
      localparam int SHI = int'(SH);
      assign opt[k] = {{SHI{fill}}, d_in[N-1:SHI]};
    end
  end

  assign d_out = opt[digit];
endmodule

// File: rtl/lsh_range_guard.sv
module lsh_range_guard #(
  parameter int N     = 32,
  parameter int AMT_W = 8
) (
  input  logic [AMT_W-1:0] amt,
  output logic             over
);
  if (longint'(N) >= (longint'(1) << AMT_W)) begin : g_never
    assign over = 1'b0;
  end else begin : g_cmp
    localparam logic [AMT_W-1:0] LIMIT = AMT_W'(N);
    assign over = (amt >= LIMIT);
  end

  always_comb begin
    if (amt == '0) assert (!over) else $error("AST_ZERO_IN_RANGE"); // R5
  end
endmodule

// File: rtl/log_shifter.sv
module log_shifter
  import log_shifter_pkg::*;
#(
  parameter int N     = 32,
  parameter int RADIX = 4,
  parameter int AMT_W = 8
) (
  input  logic [N-1:0]     data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [1:0]       mode_i,
  output logic [N-1:0]     data_o
);
  localparam int DB    = bits_for(RADIX);
  localparam int NL    = layers_for(N, RADIX);
  localparam int DIG_W = NL * DB;

  logic          go_right;
  logic          fill_bit;
  logic          over_range;
  logic [N-1:0]  pre_word;
  logic [N-1:0]  post_word;
  logic [N-1:0]  chain_out;
  logic [DIG_W-1:0] amt_digits;
  logic [N-1:0]  stage [NL+1];

  assign go_right = mode_i[0];
  assign fill_bit = mode_i[1] & mode_i[0] & data_i[N-1];

  // left shifts are done as right shifts on a bit-reversed word
  for (genvar i = 0; i < N; i++) begin : g_rev
    assign pre_word[i] = go_right ? data_i[i]    : data_i[N-1-i];
    assign data_o[i]   = go_right ? post_word[i] : post_word[N-1-i];
  end

  if (DIG_W <= AMT_W) begin : g_dig_trunc
    assign amt_digits = amt_i[DIG_W-1:0];
  end else begin : g_dig_pad
    assign amt_digits = {{(DIG_W-AMT_W){1'b0}}, amt_i};
  end

  lsh_range_guard #(.N(N), .AMT_W(AMT_W)) u_guard (
    .amt  (amt_i),
    .over (over_range)
  );

  assign stage[0] = pre_word;
  for (genvar l = 0; l < NL; l++) begin : g_layer
    lsh_layer #(
      .N(N), .R(RADIX), .STEP(step_of(RADIX, l)), .DB(DB)
    ) u_layer (
      .d_in  (stage[l]),
      .digit (amt_digits[l*DB +: DB]),
      .fill  (fill_bit),
      .d_out (stage[l+1])
    );
  end
  assign chain_out = stage[NL];
  assign post_word = over_range ? {N{fill_bit}} : chain_out;

  // port-level properties
  always_comb begin
    if (amt_i == '0)
      assert (data_o == data_i) else $error("AST_ZERO_PASS"); // R5
    if ((int'(amt_i) >= N) && (mode_i != 2'b11))
      assert (data_o == '0) else $error("AST_OVER_ZERO"); // R6
    if ((int'(amt_i) >= N) && (mode_i == 2'b11))
      assert (data_o == {N{data_i[N-1]}}) else $error("AST_OVER_SIGN"); // R7
    if (mode_i == 2'b11)
      assert (data_o[N-1] == data_i[N-1]) else $error("AST_SIGN_KEPT"); // R3
    if ((mode_i == 2'b01) && (amt_i != '0))
      assert (data_o[N-1] == 1'b0) else $error("AST_RIGHT_MSB_ZERO"); // R2
    if ((mode_i[0] == 1'b0) && (amt_i != '0))
      assert (data_o[0] == 1'b0) else $error("AST_LEFT_LSB_ZERO"); // R1
  end
endmodule

// File: tb/log_shifter_tb.sv
module log_shifter_tb;
  localparam int N = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]  din;
  logic [AW-1:0] amt;
  logic [1:0]    mode;
  logic [N-1:0]  dout2, dout4;

  int n_run = 0;
  int n_fail = 0;

  log_shifter #(.N(N), .RADIX(2), .AMT_W(AW)) u_dut (
    .data_i(din), .amt_i(amt), .mode_i(mode), .data_o(dout2));
  log_shifter #(.N(N), .RADIX(4), .AMT_W(AW)) u_dut4 (
    .data_i(din), .amt_i(amt), .mode_i(mode), .data_o(dout4));

  typedef struct packed {
    logic [N-1:0]  d;
    logic [AW-1:0] a;
    logic [1:0]    m;
    logic [N-1:0]  e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 8'd4,   2'b00, 32'h0000_0010},  // R1
    '{32'h8000_0000, 8'd31,  2'b01, 32'h0000_0001},  // R2
    '{32'h8000_0000, 8'd31,  2'b11, 32'hFFFF_FFFF},  // R3
    '{32'h7000_0000, 8'd4,   2'b11, 32'h0700_0000},  // R3
    '{32'h1234_5678, 8'd8,   2'b00, 32'h3456_7800},  // R1
    '{32'h1234_5678, 8'd8,   2'b01, 32'h0012_3456},  // R2
    '{32'hF000_000F, 8'd4,   2'b10, 32'h0000_00F0},  // R4
    '{32'hDEAD_BEEF, 8'd0,   2'b11, 32'hDEAD_BEEF},  // R5
    '{32'hDEAD_BEEF, 8'd32,  2'b00, 32'h0000_0000},  // R6
    '{32'hDEAD_BEEF, 8'd200, 2'b01, 32'h0000_0000},  // R6
    '{32'hDEAD_BEEF, 8'd32,  2'b11, 32'hFFFF_FFFF},  // R7
    '{32'h5EAD_BEEF, 8'd255, 2'b11, 32'h0000_0000},  // R7
    '{32'h8765_4321, 8'd17,  2'b01, 32'h0000_43B2},  // R9
    '{32'h8765_4321, 8'd17,  2'b11, 32'hFFFF_C3B2}   // R9
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 4:   return "R1";
      1, 5:   return "R2";
      2, 3:   return "R3";
      6:      return "R4";
      7:      return "R5";
      8, 9:   return "R6";
      10, 11: return "R7";
      default: return "R9";
    endcase
  endfunction

  // independent model built on the language operators
  function automatic logic [N-1:0] model(input logic [N-1:0] d,
                                         input int a, input logic [1:0] m);
    if (m[0] == 1'b0) return (a >= N) ? '0 : (d << a);
    if (m[1] == 1'b0) return (a >= N) ? '0 : (d >> a);
    if (a >= N) return {N{d[N-1]}};
    return N'($signed(d) >>> a);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: d=%h amt=%0d mode=%b got=%h exp=%h",
               tag, din, amt, mode, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] d, input int a, input logic [1:0] m);
    @(posedge clk);
    din = d; amt = AW'(a); mode = m;
    @(negedge clk);
  endtask

  initial begin
    din = '0; amt = '0; mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset-state zero word", dout2, '0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].d, int'(VECS[i].a), VECS[i].m);
      check(tag_of(i), dout2, VECS[i].e);
      check("R8 radix-4 table", dout4, VECS[i].e);
    end

    // sweep: every amount 0..39, every mode, several data patterns
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] pat;
      case (p)
        0: pat = 32'h8000_0001;
        1: pat = 32'h7FFF_FFFE;
        default: pat = $urandom();
      endcase
      for (int mm = 0; mm < 4; mm++) begin
        for (int a = 0; a < 40; a++) begin
          apply(pat, a, 2'(mm));
          check((a >= N) ? ((mm == 3) ? "R7" : "R6")
                : (mm == 3) ? "R3 R9" : (mm == 1) ? "R2 R9"
                : (mm == 2) ? "R4 R9" : "R1 R9",
                dout2, model(pat, a, 2'(mm)));
          check("R8 radix agreement", dout4, dout2);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got=timeout exp=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule